// File: doc/BRIEF.md
# Dual Match Timer with Write-One-to-Clear Interrupts

This block holds a set of independent compare timers, by default two, one per processor core. Each timer has a control register, a software-writable up-counter and a match register. While its run bit is set, a counter advances by one on every clock. When it equals its match value and its interrupt enable is set, the timer raises its own bit in a shared status register. The status bit drives that timer's interrupt output.

Software arms a one-shot event in four steps. It stops the timer, zeroes the counter, writes the match distance and then sets both control bits. Its interrupt handler writes a one to the timer's status bit to acknowledge the event, then stops the timer. The counter does not stop at a match. It wraps through zero and fires again only when it next equals the match value. All registers sit behind a simple single-cycle write port with a combinational read path.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every control, match, counter and status register reads zero and every interrupt output is low.
- R2: While control bit 0 (run) of a timer is set, its counter increases by one on each clock. While run is clear, the counter holds its value.
- R3: A write to a counter register loads the write data on that edge, taking priority over the increment. It also suppresses the match event of that timer on that edge.
- R4: A counter wraps from all ones to zero and keeps counting after a match.
- R5: A match event happens on the clock edge at which a running counter equals its match register. If control bit 1 (interrupt enable) of that timer is set, status bit n for timer n reads one from the next cycle on.
- R6: A timer whose interrupt enable is clear never sets its status bit.
- R7: Writing the status register (offset 0x60) clears each bit written with one and leaves each bit written with zero unchanged. Writing 0xFFFF clears all pending bits.
- R8: If a match event and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R9: Interrupt output n equals status bit n ANDed with the interrupt enable of timer n.
- R10: Register map, with timer n at base plus 4·n: control at 0x00, match at 0x18, counter at 0x48, status at 0x60. Control reads return only bits 1:0, with the upper bits zero. Unmapped offsets read zero.
- R11: Writes and events of one timer leave the counter, match, control and status bit of every other timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register at addr_i |
| addr_i | input | ADDR_W | Byte offset of the register to read or write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the register at addr_i, combinational |
| irq_o | output | N_TMR | Per-timer interrupt lines |

## Verification
The bench builds the block with its defaults: two timers, 32-bit counters and an 8-bit offset. With two timers, cross-timer interference can be tested, and the status register can be given mixed clear patterns. Because the counter is writable, the bench can preload it just below the 32-bit limit. This makes the wrap and the match at zero reachable within a few cycles. Collisions between a match event and a clearing status write happen on purpose, and they also arise from the random register traffic.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam logic [7:0] CTRL_BASE  = 8'h00;
  localparam logic [7:0] MATCH_BASE = 8'h18;
  localparam logic [7:0] CNT_BASE   = 8'h48;
  localparam logic [7:0] STAT_OFS   = 8'h60;
  localparam int CTRL_W   = 2;
  localparam int CTRL_RUN = 0;
  localparam int CTRL_IE  = 1;
endpackage

// File: rtl/dmt_decode.sv
module dmt_decode #(
  parameter int N_TMR  = 2,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_TMR-1:0]  sel_ctrl_o,
  output logic [N_TMR-1:0]  sel_match_o,
  output logic [N_TMR-1:0]  sel_cnt_o,
  output logic              sel_stat_o
);
  import dmt_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(int'(STAT_OFS));

  for (genvar g = 0; g < N_TMR; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(int'(CTRL_BASE) + 4 * g);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(int'(MATCH_BASE) + 4 * g);
    localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(int'(CNT_BASE) + 4 * g);
    assign sel_ctrl_o[g]  = (addr_i == A_CTRL);
    assign sel_match_o[g] = (addr_i == A_MATCH);
    assign sel_cnt_o[g]   = (addr_i == A_CNT);
  end

  assign sel_stat_o = (addr_i == A_STAT);
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              match_we_i,
  input  logic              cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              run_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] match_o,
  output logic              hit_o
);
  import dmt_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_q, match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
    end else begin
      if (ctrl_we_i)  ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (match_we_i) match_q <= wdata_i;
    end
  end

  // load beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_we_i)          cnt_q <= wdata_i;
    else if (ctrl_q[CTRL_RUN])  cnt_q <= cnt_q + DATA_W'(1);
  end

  assign run_o   = ctrl_q[CTRL_RUN];
  assign ie_o    = ctrl_q[CTRL_IE];
  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign hit_o   = ctrl_q[CTRL_RUN] & (cnt_q == match_q) & ~cnt_we_i;
endmodule

// File: rtl/dmt_status.sv
module dmt_status #(
  parameter int N_TMR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TMR-1:0] set_i,
  input  logic [N_TMR-1:0] clr_i,
  output logic [N_TMR-1:0] status_o
);
  logic [N_TMR-1:0] status_q;

  // hardware set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer #(
  parameter int N_TMR  = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_TMR-1:0]  irq_o
);
  logic [N_TMR-1:0] sel_ctrl, sel_match, sel_cnt;
  logic             sel_stat;
  logic [N_TMR-1:0] run, ie, hit, cnt_ld, ev_set, ev_clr, status;
  logic [N_TMR-1:0][DATA_W-1:0] cnt, match;

  dmt_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr_i      (addr_i),
    .sel_ctrl_o  (sel_ctrl),
    .sel_match_o (sel_match),
    .sel_cnt_o   (sel_cnt),
    .sel_stat_o  (sel_stat)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign cnt_ld[g] = wr_en_i & sel_cnt[g];
    dmt_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (wr_en_i & sel_ctrl[g]),
      .match_we_i (wr_en_i & sel_match[g]),
      .cnt_we_i   (cnt_ld[g]),
      .wdata_i    (wdata_i),
      .run_o      (run[g]),
      .ie_o       (ie[g]),
      .cnt_o      (cnt[g]),
      .match_o    (match[g]),
      .hit_o      (hit[g])
    );
    assign ev_set[g] = hit[g] & ie[g];
  end

  assign ev_clr = {N_TMR{wr_en_i & sel_stat}} & wdata_i[N_TMR-1:0];

  dmt_status #(.N_TMR(N_TMR)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_set),
    .clr_i    (ev_clr),
    .status_o (status)
  );

  assign irq_o = status & ie;

  always_comb begin
    rdata_o = '0;
    if (sel_stat) rdata_o[N_TMR-1:0] = status;
    for (int i = 0; i < N_TMR; i++) begin
      if (sel_ctrl[i])  rdata_o = DATA_W'({ie[i], run[i]});
      if (sel_match[i]) rdata_o = match[i];
      if (sel_cnt[i])   rdata_o = cnt[i];
    end
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int N_TMR  = 2,
  parameter int DATA_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_TMR-1:0]              run_i,
  input logic [N_TMR-1:0]              ie_i,
  input logic [N_TMR-1:0]              hit_i,
  input logic [N_TMR-1:0]              cnt_ld_i,
  input logic [N_TMR-1:0][DATA_W-1:0]  cnt_i,
  input logic [N_TMR-1:0]              status_i,
  input logic [N_TMR-1:0]              irq_i
);
  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    // R4: the modular step also covers the wrap through zero
    assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i[g] && !cnt_ld_i[g] |=> cnt_i[g] == $past(cnt_i[g]) + DATA_W'(1));

    assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[g] && !cnt_ld_i[g] |=> $stable(cnt_i[g]));

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[g] && ie_i[g] |=> status_i[g]);

    assert_rise_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_i[g]) |-> $past(hit_i[g] && ie_i[g]));

    assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ie_i[g] && !status_i[g] |=> !status_i[g]);

    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[g] |-> status_i[g] && ie_i[g]);
  end
endmodule

bind dual_match_timer dmt_checker #(.N_TMR(N_TMR), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run),
  .ie_i     (ie),
  .hit_i    (hit),
  .cnt_ld_i (cnt_ld),
  .cnt_i    (cnt),
  .status_i (status),
  .irq_i    (irq_o)
);

// File: tb/dual_match_timer_tb.sv
`timescale 1ns/1ps
module dual_match_timer_tb;
  localparam int N  = 2;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_STAT = 8'h60;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_i = ~clk_i;

  dual_match_timer u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  function automatic logic [AW-1:0] a_ctrl(int i);  return AW'(8'h00 + 4 * i); endfunction
  function automatic logic [AW-1:0] a_match(int i); return AW'(8'h18 + 4 * i); endfunction
  function automatic logic [AW-1:0] a_cnt(int i);   return AW'(8'h48 + 4 * i); endfunction

  // reference model from the requirements
  logic [1:0]    m_ctrl [N];
  logic [DW-1:0] m_match[N];
  logic [DW-1:0] m_cnt  [N];
  logic [N-1:0]  m_stat;

  always @(posedge clk_i or negedge rst_ni) begin
    logic [N-1:0] nstat;
    logic         hit;
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        m_ctrl[i] = '0; m_match[i] = '0; m_cnt[i] = '0;
      end
      m_stat = '0;
    end else begin
      nstat = m_stat;
      if (wr_en_i && addr_i == A_STAT) nstat = nstat & ~wdata_i[N-1:0];
      for (int i = 0; i < N; i++) begin
        hit = m_ctrl[i][0] && (m_cnt[i] == m_match[i]) && !(wr_en_i && addr_i == a_cnt(i));
        if (hit && m_ctrl[i][1]) nstat[i] = 1'b1;
        if (wr_en_i && addr_i == a_cnt(i)) m_cnt[i] = wdata_i;
        else if (m_ctrl[i][0])             m_cnt[i] = m_cnt[i] + 1;
        if (wr_en_i && addr_i == a_ctrl(i))  m_ctrl[i]  = wdata_i[1:0];
        if (wr_en_i && addr_i == a_match(i)) m_match[i] = wdata_i;
      end
      m_stat = nstat;
    end
  end

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a == A_STAT) r = DW'(m_stat);
    for (int i = 0; i < N; i++) begin
      if (a == a_ctrl(i))  r = DW'(m_ctrl[i]);
      if (a == a_match(i)) r = m_match[i];
      if (a == a_cnt(i))   r = m_cnt[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_stat[i] & m_ctrl[i][1];
    return v;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock: check outputs, read raddr, then drive the write for the next edge
  task automatic cyc(logic we, logic [AW-1:0] a, logic [DW-1:0] d, logic [AW-1:0] ra);
    @(negedge clk_i);
    chk("R9 irq", DW'(irq_o), DW'(exp_irq()));
    wr_en_i = 1'b0;
    addr_i  = ra;
    #0.5;
    chk("R10 read", rdata_o, exp_read(ra));
    wr_en_i = we;
    addr_i  = a;
    wdata_i = d;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    cyc(1'b1, a, d, A_STAT);
  endtask

  task automatic idle();
    cyc(1'b0, '0, '0, A_STAT);
  endtask

  task automatic peek(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    addr_i  = a;
    #0.5;
    chk(req, rdata_o, exp);
  endtask

  task automatic peek_irq(logic [N-1:0] exp, string req);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #0.5;
    chk(req, DW'(irq_o), DW'(exp));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [AW-1:0] rd_list[9];
    logic [DW-1:0] v;
    void'($urandom(32'd20240611));
    rd_list = '{8'h00, 8'h04, 8'h18, 8'h1c, 8'h48, 8'h4c, 8'h60, 8'h30, 8'h64};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int k = 0; k < 9; k++) peek(rd_list[k], '0, "R1 reset reg");
    peek_irq('0, "R1 reset irq");

    // R10 control field width, unmapped offset
    wr(a_ctrl(1), 32'hFFFF_FFFC);
    peek(a_ctrl(1), 32'h0, "R10 ctrl upper bits");
    wr(a_ctrl(1), 32'h0000_000E);
    peek(a_ctrl(1), 32'h2, "R10 ctrl field");
    wr(a_ctrl(1), 32'h0);
    peek(8'h30, 32'h0, "R10 unmapped");

    // R5 one-shot on timer 0
    wr(a_ctrl(0), 32'h0);
    wr(a_cnt(0), 32'h0);
    wr(a_match(0), 32'd5);
    wr(a_ctrl(0), 32'h3);          // edge E0
    peek(a_cnt(0), 32'd0, "R2 count after enable edge");
    repeat (4) idle();
    peek_irq(2'b00, "R5 no event before match edge");
    peek(A_STAT, 32'h1, "R5 status set after match edge");
    peek(a_cnt(0), 32'd7, "R4 count runs past match");
    peek_irq(2'b01, "R9 irq follows status");

    // R7 clear timer 0
    wr(A_STAT, 32'h1);
    peek(A_STAT, 32'h0, "R7 write one clears");

    // R4 wrap on timer 1, R11 isolation
    wr(a_ctrl(1), 32'h0);
    wr(a_cnt(1), 32'hFFFF_FFFE);
    wr(a_match(1), 32'h0);
    wr(a_ctrl(1), 32'h3);
    idle();
    peek(a_cnt(1), 32'hFFFF_FFFF, "R4 count at max");
    peek(a_cnt(1), 32'h0, "R4 count wraps to zero");
    peek(A_STAT, 32'h2, "R5 match at zero after wrap");
    peek(a_match(0), 32'd5, "R11 timer0 match untouched");
    wr(A_STAT, 32'h0);
    peek(A_STAT, 32'h2, "R7 write zero no effect");
    wr(A_STAT, 32'h0000_FFFF);
    peek(A_STAT, 32'h0, "R7 all-ones clear");
    wr(a_ctrl(1), 32'h0);
    idle();
    v = m_cnt[1];
    peek(a_cnt(1), v, "R2 stopped counter holds");
    peek(a_cnt(1), v, "R2 stopped counter holds again");

    // R6 interrupt enable clear
    wr(a_ctrl(0), 32'h0);
    wr(a_cnt(0), 32'h0);
    wr(a_match(0), 32'd2);
    wr(a_ctrl(0), 32'h1);
    repeat (6) idle();
    peek(A_STAT, 32'h0, "R6 masked timer no status");
    peek_irq(2'b00, "R6 masked timer no irq");

    // R3 load suppresses event
    wr(a_ctrl(0), 32'h0);
    wr(a_cnt(0), 32'd10);
    wr(a_match(0), 32'd10);
    wr(a_ctrl(0), 32'h3);
    wr(a_cnt(0), 32'd20);
    peek(A_STAT, 32'h0, "R3 load suppresses match");
    peek(a_cnt(0), 32'd21, "R3 loaded value then counts");
    peek(a_cnt(1), v, "R11 timer1 counter untouched");

    // R8 set wins over clear
    wr(a_ctrl(0), 32'h0);
    wr(a_cnt(0), 32'h0);
    wr(a_match(0), 32'd3);
    wr(a_ctrl(0), 32'h3);          // E0
    idle(); idle(); idle();
    wr(A_STAT, 32'h1);             // lands on E4, the hit edge
    peek(A_STAT, 32'h1, "R8 set beats clear");
    wr(A_STAT, 32'h1);
    peek(A_STAT, 32'h0, "R7 later clear works");

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int            op, t;
      logic [AW-1:0] ra;
      ra = rd_list[$urandom % 9];
      op = int'($urandom % 10);
      t  = int'($urandom % N);
      case (op)
        4: cyc(1'b1, a_ctrl(t), $urandom % 8, ra);
        5: cyc(1'b1, a_match(t), $urandom % 48, ra);
        6: cyc(1'b1, a_cnt(t), ($urandom % 4 == 0) ? (32'hFFFF_FFF0 + $urandom % 16) : ($urandom % 48), ra);
        7: cyc(1'b1, A_STAT, ($urandom % 5 == 0) ? 32'h0000_FFFF : ($urandom % 4), ra);
        default: cyc(1'b0, '0, '0, ra);
      endcase
    end
    idle();
    summary();
  end
endmodule